// File: doc/BRIEF.md
# Index-Relative Byte Transfer Sequencer

This block runs the memory operations of a small interpreter core that work through a 12-bit index pointer. It has three groups of operations:

- **Pointer operations:** load the index, add a register value to it, or point it at the 5-byte glyph for a hex digit. Each takes one step.
- **Decimal store:** write a byte value to memory as three decimal digit bytes.
- **Register-range transfers:** copy registers 0 through x to memory, or fill registers 0 through x from memory, one byte per cycle.

The instruction decoder issues one command at a time. The command carries an operation code, a register number, the register's value and a 12-bit address. The block then drives a byte-wide memory port and a register-file read port and write port. While a burst runs, `busy` stays high. A one-cycle `done` marks the end of every accepted command. Commands that arrive while `busy` is high are dropped.

Top module: `idx_xfer_seq`

## Requirements
- R1: After synchronous reset the index reads 0x000 and `busy`, `done`, `glyph_warn`, `mem_we`, `mem_re` and `rf_we` are all low.
- R2: Op code 3 (decimal store) writes the hundreds, tens and ones digits of `cmd_val` (values 0..9) to index, index+1 and index+2, in that order, on three consecutive cycles. The index is left unchanged.
- R3: Op code 4 (range store) writes registers 0..`cmd_reg` in ascending order to consecutive bytes starting at the index, one per cycle. The index ends at its start value plus `cmd_reg`+1.
- R4: Op code 5 (range load) reads consecutive bytes from the index into registers 0..`cmd_reg`, in ascending order, one per cycle. Registers above `cmd_reg` are not written. The index ends at its start value plus `cmd_reg`+1.
- R5: Op code 2 (glyph) sets the index to 5 × `cmd_val[3:0]`. `glyph_warn` is high together with `done` exactly when `cmd_val[7:4]` is nonzero.
- R6: Op code 1 (add) adds the 8-bit `cmd_val`, zero-extended, to the index.
- R7: Op code 0 (set) loads the index from `cmd_addr`.
- R8: The index and every memory address wrap modulo 4096.
- R9: `done` is high for one cycle. For op codes 0..2 it comes one cycle after acceptance. For bursts it comes one cycle after the last byte. A command presented while `busy` is high has no effect.
- R10: Op codes 6 and 7 are ignored: no `done`, no memory or register write, no index change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when not busy |
| cmd_op | input | 3 | Operation code (0 set, 1 add, 2 glyph, 3 decimal, 4 range store, 5 range load) |
| cmd_reg | input | 4 | Highest register number of a range transfer |
| cmd_val | input | 8 | Register value operand |
| cmd_addr | input | 12 | Address operand for set |
| mem_addr | output | 12 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe (data returned combinationally) |
| mem_rdata | input | 8 | Memory read data |
| rf_raddr | output | 4 | Register-file read address |
| rf_rdata | input | 8 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 4 | Register-file write address |
| rf_wdata | output | 8 | Register-file write data |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |
| glyph_warn | output | 1 | Glyph operand exceeded one hex digit |
| index_q | output | 12 | Current index value |

## Verification
**Pointer operations.** Set, add and glyph change `index_q` and raise `done` in the cycle after the accepting edge. The bench samples them on the first falling edge after acceptance.

**Bursts.** A burst of N bytes drives its strobes during the N cycles after acceptance and raises `done` in the cycle after the last byte. The bench counts falling edges from acceptance until `done` and compares the count with N. It then checks that `done` has dropped one cycle later.

**Data checks.** Memory and register contents, the order of the write log and the final index are compared once `done` is seen. By then every write of the burst has landed.

// File: rtl/idx_xfer_pkg.sv
package idx_xfer_pkg;

    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 8;
    localparam int RSEL_W      = 4;
    localparam int DIGITS      = 3;
    localparam int GLYPH_BYTES = 5;
    localparam int GLYPH_BASE  = 0;

    typedef enum logic [2:0] {
        OP_SET   = 3'd0,
        OP_ADD   = 3'd1,
        OP_GLYPH = 3'd2,
        OP_BCD   = 3'd3,
        OP_STORE = 3'd4,
        OP_LOAD  = 3'd5
    } cmd_op_e;

    typedef enum logic [2:0] {
        IX_HOLD,
        IX_SET,
        IX_ADD,
        IX_GLYPH,
        IX_STEP
    } idx_act_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BCD,
        ST_STORE,
        ST_LOAD
    } seq_state_e;

    typedef struct packed {
        cmd_op_e            op;
        logic [RSEL_W-1:0]  rsel;
        logic [DATA_W-1:0]  val;
        logic [ADDR_W-1:0]  addr;
    } cmd_t;

    function automatic logic op_legal(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

endpackage

// File: rtl/idx_bcd_conv.sv
module idx_bcd_conv #(
    parameter int DW = idx_xfer_pkg::DATA_W,
    parameter int ND = idx_xfer_pkg::DIGITS
) (
    input  logic [DW-1:0]       bin_i,
    output logic [ND-1:0][3:0]  dig_o
);
    localparam int SW = ND * 4 + DW;

    logic [DW:0][SW-1:0]   stg;
    logic [DW-1:0][SW-1:0] adj;

    assign stg[0] = {{(ND*4){1'b0}}, bin_i};

    for (genvar i = 0; i < DW; i++) begin : g_step
        assign adj[i][DW-1:0] = stg[i][DW-1:0];
        for (genvar d = 0; d < ND; d++) begin : g_dig
            assign adj[i][DW+4*d +: 4] = (stg[i][DW+4*d +: 4] >= 4'd5)
                                       ? stg[i][DW+4*d +: 4] + 4'd3
                                       : stg[i][DW+4*d +: 4];
        end
        assign stg[i+1] = {adj[i][SW-2:0], 1'b0};
    end

    assign dig_o = stg[DW][SW-1:DW];

    always_comb begin
        for (int d = 0; d < ND; d++) begin
            assert_digit_range_R2: assert (dig_o[d] <= 4'd9);
        end
    end

endmodule

// File: rtl/idx_ptr_unit.sv
module idx_ptr_unit
    import idx_xfer_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int OW = RSEL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  idx_act_e        act_i,
    input  logic [AW-1:0]   set_addr_i,
    input  logic [DW-1:0]   val_i,
    input  logic [OW-1:0]   offset_i,
    output logic [AW-1:0]   idx_o,
    output logic [AW-1:0]   addr_o
);
    localparam logic [AW-1:0] G_BASE   = AW'(GLYPH_BASE);
    localparam logic [AW-1:0] G_STRIDE = AW'(GLYPH_BYTES);

    logic [AW-1:0] idx_q;
    logic [AW-1:0] glyph_addr;

    assign glyph_addr = G_BASE + G_STRIDE * AW'(val_i[3:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else begin
            case (act_i)
                IX_SET:   idx_q <= set_addr_i;
                IX_ADD:   idx_q <= idx_q + AW'(val_i);
                IX_GLYPH: idx_q <= glyph_addr;
                IX_STEP:  idx_q <= idx_q + AW'(1);
                default:  idx_q <= idx_q;
            endcase
        end
    end

    assign idx_o  = idx_q;
    assign addr_o = idx_q + AW'(offset_i);

    assert_glyph_grid_R5: assert property (@(posedge clk) disable iff (rst)
        (act_i == IX_GLYPH) |=>
            ((int'(idx_q) - GLYPH_BASE) % GLYPH_BYTES == 0) &&
            (int'(idx_q) < GLYPH_BASE + 16 * GLYPH_BYTES));

    assert_step_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (act_i == IX_STEP && idx_q == '1) |=> (idx_q == '0));

endmodule

// File: rtl/idx_seq_ctl.sv
module idx_seq_ctl
    import idx_xfer_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int RW = RSEL_W,
    parameter int ND = DIGITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid_i,
    input  cmd_t                cmd_i,
    input  logic [ND-1:0][3:0]  dig_i,
    input  logic [AW-1:0]       idx_i,
    input  logic [DW-1:0]       mem_rdata_i,
    input  logic [DW-1:0]       rf_rdata_i,
    output idx_act_e            act_o,
    output logic [RW-1:0]       offset_o,
    output logic                mem_we_o,
    output logic                mem_re_o,
    output logic [DW-1:0]       mem_wdata_o,
    output logic [RW-1:0]       rf_raddr_o,
    output logic                rf_we_o,
    output logic [RW-1:0]       rf_waddr_o,
    output logic [DW-1:0]       rf_wdata_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                warn_o
);
    localparam int CW = (ND > 1) ? $clog2(ND) : 1;

    seq_state_e          state_q;
    logic [RW-1:0]       cnt_q;
    logic [RW-1:0]       last_q;
    logic [ND-1:0][3:0]  dig_q;
    logic                done_q;
    logic                warn_q;
    logic                accept;
    logic                burst_end;
    logic [CW-1:0]       dsel;

    assign accept    = cmd_valid_i && (state_q == ST_IDLE) && op_legal(cmd_i.op);
    assign burst_end = (state_q != ST_IDLE) && (cnt_q == last_q);
    assign dsel      = CW'(ND - 1) - cnt_q[CW-1:0];

    always_comb begin
        act_o = IX_HOLD;
        if (accept) begin
            case (cmd_i.op)
                OP_SET:   act_o = IX_SET;
                OP_ADD:   act_o = IX_ADD;
                OP_GLYPH: act_o = IX_GLYPH;
                default:  act_o = IX_HOLD;
            endcase
        end else if (state_q == ST_STORE || state_q == ST_LOAD) begin
            act_o = IX_STEP;
        end
    end

    always_comb begin
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;
        mem_wdata_o = '0;
        rf_we_o     = 1'b0;
        offset_o    = '0;
        case (state_q)
            ST_BCD: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = DW'(dig_q[dsel]);
                offset_o    = cnt_q;
            end
            ST_STORE: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = rf_rdata_i;
            end
            ST_LOAD: begin
                mem_re_o = 1'b1;
                rf_we_o  = 1'b1;
            end
            default: ;
        endcase
    end

    assign rf_raddr_o = cnt_q;
    assign rf_waddr_o = cnt_q;
    assign rf_wdata_o = mem_rdata_i;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign warn_o     = warn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            last_q  <= '0;
            dig_q   <= '0;
            done_q  <= 1'b0;
            warn_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            warn_q <= 1'b0;
            if (accept) begin
                cnt_q <= '0;
                case (cmd_i.op)
                    OP_SET, OP_ADD: done_q <= 1'b1;
                    OP_GLYPH: begin
                        done_q <= 1'b1;
                        warn_q <= (cmd_i.val[DW-1:4] != '0);
                    end
                    OP_BCD: begin
                        state_q <= ST_BCD;
                        last_q  <= RW'(ND - 1);
                        dig_q   <= dig_i;
                    end
                    OP_STORE: begin
                        state_q <= ST_STORE;
                        last_q  <= cmd_i.rsel;
                    end
                    OP_LOAD: begin
                        state_q <= ST_LOAD;
                        last_q  <= cmd_i.rsel;
                    end
                    default: ;
                endcase
            end else if (state_q != ST_IDLE) begin
                if (burst_end) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + RW'(1);
                end
            end
        end
    end

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_write_in_burst_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o || rf_we_o) |-> busy_o);

    assert_bcd_index_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BCD) |=> (idx_i == $past(idx_i)));

    assert_range_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STORE || state_q == ST_LOAD) |=> (idx_i == AW'($past(idx_i) + 1)));

    assert_load_no_mem_write_R4: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> !mem_we_o);

    assert_warn_with_done_R5: assert property (@(posedge clk) disable iff (rst)
        warn_o |-> done_o);

endmodule

// File: rtl/idx_xfer_seq.sv
module idx_xfer_seq
    import idx_xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic [3:0]  cmd_reg,
    input  logic [7:0]  cmd_val,
    input  logic [11:0] cmd_addr,
    output logic [11:0] mem_addr,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata,
    output logic [3:0]  rf_raddr,
    input  logic [7:0]  rf_rdata,
    output logic        rf_we,
    output logic [3:0]  rf_waddr,
    output logic [7:0]  rf_wdata,
    output logic        busy,
    output logic        done,
    output logic        glyph_warn,
    output logic [11:0] index_q
);
    cmd_t                    cmd;
    idx_act_e                act;
    logic [RSEL_W-1:0]       offset;
    logic [DIGITS-1:0][3:0]  digits;

    assign cmd.op   = cmd_op_e'(cmd_op);
    assign cmd.rsel = cmd_reg;
    assign cmd.val  = cmd_val;
    assign cmd.addr = cmd_addr;

    idx_bcd_conv #(.DW(DATA_W), .ND(DIGITS)) u_bcd (
        .bin_i (cmd_val),
        .dig_o (digits)
    );

    idx_seq_ctl #(.AW(ADDR_W), .DW(DATA_W), .RW(RSEL_W), .ND(DIGITS)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (cmd_valid),
        .cmd_i       (cmd),
        .dig_i       (digits),
        .idx_i       (index_q),
        .mem_rdata_i (mem_rdata),
        .rf_rdata_i  (rf_rdata),
        .act_o       (act),
        .offset_o    (offset),
        .mem_we_o    (mem_we),
        .mem_re_o    (mem_re),
        .mem_wdata_o (mem_wdata),
        .rf_raddr_o  (rf_raddr),
        .rf_we_o     (rf_we),
        .rf_waddr_o  (rf_waddr),
        .rf_wdata_o  (rf_wdata),
        .busy_o      (busy),
        .done_o      (done),
        .warn_o      (glyph_warn)
    );

    idx_ptr_unit #(.AW(ADDR_W), .DW(DATA_W), .OW(RSEL_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .act_i      (act),
        .set_addr_i (cmd_addr),
        .val_i      (cmd_val),
        .offset_i   (offset),
        .idx_o      (index_q),
        .addr_o     (mem_addr)
    );

    assert_illegal_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op > 3'd5 && !busy) |=> (!done && $stable(index_q)));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (index_q == '0 && !busy && !done && !glyph_warn));

endmodule

// File: tb/idx_xfer_seq_bench.sv
module idx_xfer_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [3:0]  cmd_reg = '0;
    logic [7:0]  cmd_val = '0;
    logic [11:0] cmd_addr = '0;
    logic [11:0] mem_addr;
    logic        mem_we, mem_re, rf_we, busy, done, glyph_warn;
    logic [7:0]  mem_wdata, mem_rdata, rf_rdata, rf_wdata;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [11:0] index_q;

    logic [7:0]  mem [0:4095];
    logic [7:0]  rf  [0:15];
    logic [11:0] wlog_a [0:63];
    logic [7:0]  wlog_d [0:63];
    int          wn = 0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    idx_xfer_seq u_idx_xfer_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_val(cmd_val), .cmd_addr(cmd_addr),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .busy(busy), .done(done),
        .glyph_warn(glyph_warn), .index_q(index_q)
    );

    assign mem_rdata = mem[mem_addr];
    assign rf_rdata  = rf[rf_raddr];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wlog_a[wn[5:0]] <= mem_addr;
            wlog_d[wn[5:0]] <= mem_wdata;
            wn <= wn + 1;
        end
        if (rf_we) rf[rf_waddr] <= rf_wdata;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic issue(input int op, input int rg, input int val, input int addr);
        @(negedge clk);
        cmd_op = 3'(op); cmd_reg = 4'(rg); cmd_val = 8'(val); cmd_addr = 12'(addr);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input int beats, input string tag);
        int n = 0;
        while (done !== 1'b1 && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == beats, {tag, " done latency"}, n, beats);
    endtask

    task automatic check_done_drops(input string tag);
        @(negedge clk);
        check(done == 1'b0, {tag, " done one cycle"}, int'(done), 0);
    endtask

    // {op, val, addr, expected index, expected warn}
    localparam int NV = 10;
    localparam logic [35:0] VEC [NV] = '{
        {3'd0, 8'h00, 12'h123, 12'h123, 1'b0},   // R7 set
        {3'd1, 8'h45, 12'h000, 12'h168, 1'b0},   // R6 add
        {3'd1, 8'hFF, 12'h000, 12'h267, 1'b0},   // R6 add max
        {3'd0, 8'h00, 12'hFF0, 12'hFF0, 1'b0},   // R7 set near top
        {3'd1, 8'h20, 12'h000, 12'h010, 1'b0},   // R8 add wraps
        {3'd2, 8'h00, 12'h000, 12'h000, 1'b0},   // R5 glyph 0
        {3'd2, 8'h0F, 12'h000, 12'h04B, 1'b0},   // R5 glyph F
        {3'd2, 8'h07, 12'h000, 12'h023, 1'b0},   // R5 glyph 7
        {3'd2, 8'h3A, 12'h000, 12'h032, 1'b1},   // R5 oversize operand
        {3'd2, 8'hF1, 12'h000, 12'h005, 1'b1}    // R5 oversize operand
    };

    task automatic bcd_case(input int base, input int v);
        int st;
        int ew [3];
        ew[0] = v / 100; ew[1] = (v / 10) % 10; ew[2] = v % 10;
        issue(0, 0, 0, base);
        wait_done(0, "R7 set before decimal");
        st = wn;
        issue(3, 0, v, 0);
        wait_done(3, "R2 decimal");
        for (int k = 0; k < 3; k++) begin
            check(wlog_a[(st + k) % 64] == 12'(base + k), "R2/R8 digit address",
                  int'(wlog_a[(st + k) % 64]), (base + k) % 4096);
            check(wlog_d[(st + k) % 64] == 8'(ew[k]), "R2 digit value",
                  int'(wlog_d[(st + k) % 64]), ew[k]);
        end
        check(wn - st == 3, "R2 write count", wn - st, 3);
        check(index_q == 12'(base), "R2 index unchanged", int'(index_q), base);
        check_done_drops("R9 decimal");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        summary();
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7);
        for (int i = 0; i < 16; i++) rf[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state (reset held for three edges)
        check(index_q == 12'h000, "R1 index", int'(index_q), 0);
        check(!busy && !done && !glyph_warn, "R1 status", {busy, done, glyph_warn}, 0);
        check(!mem_we && !mem_re && !rf_we, "R1 strobes", {mem_we, mem_re, rf_we}, 0);

        // pointer operations from the vector table
        for (int i = 0; i < NV; i++) begin
            issue(int'(VEC[i][35:33]), 0, int'(VEC[i][32:25]), int'(VEC[i][24:13]));
            wait_done(0, "R9 pointer op");
            check(index_q == VEC[i][12:1], "R5/R6/R7 index", int'(index_q), int'(VEC[i][12:1]));
            check(glyph_warn == VEC[i][0], "R5 warn", int'(glyph_warn), int'(VEC[i][0]));
            check_done_drops("R9 pointer op");
        end

        // decimal store
        bcd_case(12'h200, 0);
        bcd_case(12'h300, 255);
        bcd_case(12'h310, 109);
        bcd_case(12'hFFE, 47);     // R8 digits wrap past 0xFFF

        // range store, full register set
        for (int i = 0; i < 16; i++) rf[i] = 8'(8'hA0 + i * 3);
        issue(0, 0, 0, 12'h400);
        wait_done(0, "R7 set");
        begin
            int st;
            st = wn;
            issue(4, 15, 0, 0);
            wait_done(16, "R3 store 16");
            for (int k = 0; k < 16; k++) begin
                check(wlog_a[(st + k) % 64] == 12'(12'h400 + k), "R3 ascending address",
                      int'(wlog_a[(st + k) % 64]), 12'h400 + k);
                check(mem[12'h400 + k] == 8'(8'hA0 + k * 3), "R3 stored byte",
                      int'(mem[12'h400 + k]), 8'hA0 + k * 3);
            end
            check(index_q == 12'h410, "R3 index advance", int'(index_q), 12'h410);
            check_done_drops("R9 store");
        end

        // range store, single register
        issue(0, 0, 0, 12'h500);
        wait_done(0, "R7 set");
        issue(4, 0, 0, 0);
        wait_done(1, "R3 store 1");
        check(mem[12'h500] == 8'hA0, "R3 single byte", int'(mem[12'h500]), 8'hA0);
        check(mem[12'h501] == 8'(12'h501 * 7), "R3 no extra byte", int'(mem[12'h501]), (12'h501 * 7) % 256);
        check(index_q == 12'h501, "R3 single index", int'(index_q), 12'h501);

        // range store across the top of memory
        issue(0, 0, 0, 12'hFFF);
        wait_done(0, "R7 set");
        issue(4, 1, 0, 0);
        wait_done(2, "R8 store wrap");
        check(mem[12'hFFF] == 8'hA0 && mem[12'h000] == 8'hA3, "R8 wrapped bytes",
              {mem[12'hFFF], mem[12'h000]}, 16'hA0A3);
        check(index_q == 12'h001, "R8 index wrap", int'(index_q), 1);

        // range load
        for (int k = 0; k < 8; k++) mem[12'h600 + k] = 8'(8'h11 * (k + 1));
        for (int i = 0; i < 16; i++) rf[i] = 8'hEE;
        issue(0, 0, 0, 12'h600);
        wait_done(0, "R7 set");
        issue(5, 5, 0, 0);
        wait_done(6, "R4 load 6");
        for (int k = 0; k < 6; k++)
            check(rf[k] == 8'(8'h11 * (k + 1)), "R4 loaded reg", int'(rf[k]), (8'h11 * (k + 1)) % 256);
        check(rf[6] == 8'hEE, "R4 reg above range untouched", int'(rf[6]), 8'hEE);
        check(index_q == 12'h606, "R4 index advance", int'(index_q), 12'h606);

        // command during burst is dropped
        for (int i = 0; i < 16; i++) rf[i] = 8'(i);
        issue(0, 0, 0, 12'h700);
        wait_done(0, "R7 set");
        issue(4, 7, 0, 0);
        cmd_op = 3'd1; cmd_val = 8'h40; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(7, "R9 busy burst");
        check(index_q == 12'h708, "R9 busy command ignored", int'(index_q), 12'h708);
        check_done_drops("R9 busy");
        check(index_q == 12'h708, "R9 no late add", int'(index_q), 12'h708);

        // illegal op codes
        for (int c = 6; c < 8; c++) begin
            int st;
            st = wn;
            issue(c, 3, 8'h55, 12'h123);
            check(done == 1'b0, "R10 no done", int'(done), 0);
            @(negedge clk);
            check(index_q == 12'h708 && !busy, "R10 index unchanged", int'(index_q), 12'h708);
            check(wn == st, "R10 no write", wn - st, 0);
        end

        summary();
    end

endmodule